// File: doc/BRIEF.md
# Sliding-Column Convolution Readout Sequencer

This block is the digital controller of a row-parallel 3x3 convolution array that sits beside an image sensor. The pixel array has 64 active columns and one dummy padding column on each side, so 66 physical columns are addressed. For each processing period the sequencer enables a window of three adjacent column switches. During the first half of the period it resets the enabled pixels and keeps the multiply-add circuitry powered down. During the second half it powers the multiply-add circuitry up and strobes pixel sampling. When the period closes it announces which output column is ready, then moves the window on.

A start request latches nine 4-bit kernel weights and a stride value. The weights stay in local registers and are presented to the multipliers for the whole frame. The window starts at physical columns 0..2 and its base advances by the stride each period. The frame ends after the last window that still fits inside column 65, and a single-cycle done flag follows.

The analog side cannot hold a result while it waits, so the column-valid strobe carries no back-pressure: a capture stage must take the centre index in the cycle the strobe is high.

Top module: `conv_col_sequencer`

## Requirements
- R1: After reset, `mac_pwrdn_o` is 1. `col_en_o`, `pix_rst_o`, `pix_samp_o`, `col_valid_o`, `frame_done_o` and `weights_o` are all 0.
- R2: A `start_i` seen while idle latches `weights_i` (tap k in bits 4k+3..4k) and `stride_i` (0 is treated as 1). The first period then enables exactly physical columns 0, 1 and 2, where bit i of `col_en_o` is column i. Later changes to the inputs do not alter the latched values.
- R3: Each period lasts SUB_CYCLES clock cycles, with H = SUB_CYCLES/2 and period cycles numbered from 0.
  - `mac_pwrdn_o` is 1 in cycles 0..H-1 and 0 in cycles H..SUB_CYCLES-1.
  - `pix_rst_o` is 1 in cycles 0..H-2.
  - `pix_samp_o` is 1 in cycles H..SUB_CYCLES-2.
- R4: `pix_rst_o` and `pix_samp_o` are never 1 together, and each is followed by a cycle in which neither is 1.
- R5: `col_valid_o` is 1 only in the last cycle of each period. In that cycle `col_idx_o` equals the window base + 1, which is the centre column.
- R6: Outside its first period the window base is the previous base plus the latched stride. Exactly three adjacent columns are enabled while running. The last window is the one whose base + stride + 2 would exceed 65, so a frame has (63 / stride) + 1 periods, rounded down.
- R7: `frame_done_o` is 1 for exactly the one cycle after the last period ends. It is 0 otherwise.
- R8: `start_i` while a frame runs is ignored: the weights, the stride and the column sequence continue unchanged.
- R9: While idle, `mac_pwrdn_o` is 1 and `col_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, SUB_CYCLES cycles per processing period |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame; honoured only when idle |
| stride_i | input | 3 | Window step per period (0 acts as 1) |
| weights_i | input | 36 | Nine 4-bit kernel taps, tap k at bits 4k+3..4k |
| col_en_o | output | 66 | Column switch enables, bit i = physical column i |
| pix_rst_o | output | 1 | Pixel reset strobe (first half-period) |
| pix_samp_o | output | 1 | Pixel sample strobe (second half-period) |
| mac_pwrdn_o | output | 1 | Multiply-add power-down, active high |
| col_valid_o | output | 1 | Output column result ready, one cycle per period |
| col_idx_o | output | 7 | Centre column index of the ready result |
| frame_done_o | output | 1 | One-cycle pulse after the final period |
| weights_o | output | 36 | Latched kernel taps held for the multipliers |

## Verification
Two functions can fall in the same clock cycle. The first is the column-valid strobe of the last period. The second is the decision to end the frame and return to idle. The strobe must still carry the correct centre index, and the done flag must follow one cycle later rather than in the same cycle. The bench sweeps every stride value and predicts the exact number of periods from the arithmetic in R6. It compares every output on every cycle of each frame and on the cycle after it, so it judges a premature, late or doubled done pulse. A second overlap is a start request in the middle of a running frame. The bench fires one with different weights and stride, then confirms that neither the latched taps nor the window sequence change.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/conv_seq_phase.sv
// Sub-cycle counter for one processing period: derives the half-period
// strobes with a one-cycle guard gap at the end of each half.
module conv_seq_phase #(
  parameter int SUB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic pix_rst_o,
  output logic pix_samp_o,
  output logic pwrdn_o,
  output logic last_sub_o
);
  localparam int CW = (SUB_CYCLES > 2) ? $clog2(SUB_CYCLES) : 1;
  localparam int HALF = SUB_CYCLES / 2;
  localparam logic [CW-1:0] LAST_C  = CW'(SUB_CYCLES - 1);
  localparam logic [CW-1:0] HALF_C  = CW'(HALF);
  localparam logic [CW-1:0] RGAP_C  = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q == LAST_C)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    pwrdn_o    = !run_i || (cnt_q < HALF_C);
    pix_rst_o  = run_i && (cnt_q < RGAP_C);
    pix_samp_o = run_i && (cnt_q >= HALF_C) && (cnt_q < LAST_C);
    last_sub_o = run_i && (cnt_q == LAST_C);
  end
endmodule

// File: rtl/conv_seq_window.sv
// Window base register, stride latch, last-window test and the
// per-column switch decode.
module conv_seq_window #(
  parameter int PHYS     = 66,
  parameter int KSIZE    = 3,
  parameter int STRIDE_W = 3,
  parameter int BW       = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                run_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic [BW-1:0]       base_o,
  output logic                last_o,
  output logic [PHYS-1:0]     col_en_o
);
  localparam int SW = BW + STRIDE_W + 1;
  localparam logic [SW-1:0] TAIL_C = SW'(KSIZE - 1);
  localparam logic [SW-1:0] EDGE_C = SW'(PHYS - 1);

  logic [STRIDE_W-1:0] stride_q;
  logic [BW-1:0]       base_q;
  logic [SW-1:0]       next_far;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
      base_q   <= '0;
    end else if (load_i) begin
      stride_q <= (stride_i == '0) ? STRIDE_W'(1) : stride_i;
      base_q   <= '0;
    end else if (step_i) begin
      base_q   <= base_q + BW'(stride_q);
    end
  end

  assign next_far = SW'(base_q) + SW'(stride_q) + TAIL_C;
  assign last_o   = next_far > EDGE_C;
  assign base_o   = base_q;

  for (genvar gi = 0; gi < PHYS; gi++) begin : g_col
    localparam logic [BW:0] IDX = (BW+1)'(gi);
    assign col_en_o[gi] = run_i && (IDX >= {1'b0, base_q}) &&
                          (IDX < ({1'b0, base_q} + (BW+1)'(KSIZE)));
  end
endmodule

// File: rtl/conv_seq_weights.sv
// Local kernel tap storage, loaded once per frame.
module conv_seq_weights #(
  parameter int NTAP = 9,
  parameter int WW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NTAP*WW-1:0] wt_i,
  output logic [NTAP*WW-1:0] wt_o
);
  for (genvar gt = 0; gt < NTAP; gt++) begin : g_tap
    logic [WW-1:0] tap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tap_q <= '0;
      else if (load_i) tap_q <= wt_i[gt*WW +: WW];
    end
    assign wt_o[gt*WW +: WW] = tap_q;
  end
endmodule

// File: rtl/conv_col_sequencer.sv
module conv_col_sequencer #(
  parameter int ACT_COLS   = 64,
  parameter int PAD        = 1,
  parameter int KSIZE      = 3,
  parameter int WW         = 4,
  parameter int STRIDE_W   = 3,
  parameter int SUB_CYCLES = 4,
  localparam int PHYS = ACT_COLS + 2 * PAD,
  localparam int BW   = $clog2(PHYS + 1),
  localparam int NW   = KSIZE * KSIZE * WW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [NW-1:0]       weights_i,
  output logic [PHYS-1:0]     col_en_o,
  output logic                pix_rst_o,
  output logic                pix_samp_o,
  output logic                mac_pwrdn_o,
  output logic                col_valid_o,
  output logic [BW-1:0]       col_idx_o,
  output logic                frame_done_o,
  output logic [NW-1:0]       weights_o
);
  import conv_seq_pkg::*;

  seq_state_e    state_q;
  logic          run;
  logic          load;
  logic          last_sub;
  logic          last_win;
  logic          finish;
  logic          done_q;
  logic [BW-1:0] base;

  assign run    = (state_q == SEQ_RUN);
  assign load   = start_i && (state_q == SEQ_IDLE);
  assign finish = last_sub && last_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (load)        state_q <= SEQ_RUN;
      else if (finish) state_q <= SEQ_IDLE;
    end
  end

  conv_seq_phase #(.SUB_CYCLES(SUB_CYCLES)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .pix_rst_o  (pix_rst_o),
    .pix_samp_o (pix_samp_o),
    .pwrdn_o    (mac_pwrdn_o),
    .last_sub_o (last_sub)
  );

  conv_seq_window #(
    .PHYS(PHYS), .KSIZE(KSIZE), .STRIDE_W(STRIDE_W), .BW(BW)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (last_sub && !last_win),
    .run_i    (run),
    .stride_i (stride_i),
    .base_o   (base),
    .last_o   (last_win),
    .col_en_o (col_en_o)
  );

  conv_seq_weights #(.NTAP(KSIZE * KSIZE), .WW(WW)) u_weights (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .wt_i   (weights_i),
    .wt_o   (weights_o)
  );

  assign col_valid_o  = last_sub;
  assign col_idx_o    = base + BW'((KSIZE - 1) / 2);
  assign frame_done_o = done_q;
endmodule

// File: rtl/conv_col_sequencer_chk.sv
module conv_col_sequencer_chk #(
  parameter int PHYS = 66,
  parameter int NW   = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PHYS-1:0] col_en_o,
  input logic            pix_rst_o,
  input logic            pix_samp_o,
  input logic            mac_pwrdn_o,
  input logic            col_valid_o,
  input logic            frame_done_o,
  input logic [NW-1:0]   weights_o
);
  logic busy;
  assign busy = (col_en_o != '0);

  // R4: strobes exclusive
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_rst_o && pix_samp_o));
  // R4: guard cycle after reset strobe
  a_r4_gap_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rst_o |=> !pix_samp_o);
  // R4: guard cycle after sample strobe
  a_r4_gap_after_samp: assert property (@(posedge clk) disable iff (!rst_n)
    pix_samp_o |=> !pix_rst_o);
  // R3: sampling only with multiply-add powered
  a_r3_samp_powered: assert property (@(posedge clk) disable iff (!rst_n)
    pix_samp_o |-> !mac_pwrdn_o);
  // R3: reset only while powered down
  a_r3_rst_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rst_o |-> mac_pwrdn_o);
  // R6: exactly three columns when running
  a_r6_three_cols: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(col_en_o) == 3));
  // R5: valid follows the sample half
  a_r5_valid_after_samp: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o |-> $past(pix_samp_o));
  // R7: done is a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  // R9: idle means power-down
  a_r9_idle_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mac_pwrdn_o);
  // R8: taps frozen while a frame runs
  a_r8_weights_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(weights_o));
endmodule

bind conv_col_sequencer conv_col_sequencer_chk #(.PHYS(PHYS), .NW(NW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .col_en_o     (col_en_o),
  .pix_rst_o    (pix_rst_o),
  .pix_samp_o   (pix_samp_o),
  .mac_pwrdn_o  (mac_pwrdn_o),
  .col_valid_o  (col_valid_o),
  .frame_done_o (frame_done_o),
  .weights_o    (weights_o)
);

// File: tb/conv_col_sequencer_bench.sv
module conv_col_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 4;
  localparam int H    = P / 2;
  localparam int PHYS = 66;
  localparam int K    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  stride = '0;
  logic [35:0] weights = '0;
  logic [65:0] col_en;
  logic        pix_rst, pix_samp, pwrdn, col_valid, done;
  logic [6:0]  col_idx;
  logic [35:0] wt_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  conv_col_sequencer u_conv_col_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stride_i(stride),
    .weights_i(weights), .col_en_o(col_en), .pix_rst_o(pix_rst),
    .pix_samp_o(pix_samp), .mac_pwrdn_o(pwrdn), .col_valid_o(col_valid),
    .col_idx_o(col_idx), .frame_done_o(done), .weights_o(wt_out)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_frame(input int sv, input logic [35:0] w, input bit poke);
    int s_eff = (sv == 0) ? 1 : sv;
    int n = (PHYS - K) / s_eff + 1;
    @(negedge clk);
    start = 1'b1; stride = 3'(sv); weights = w;
    @(negedge clk);
    start = 1'b0; stride = 3'd5; weights = ~w;  // R2: later input changes ignored
    for (int t = 0; t <= n * P; t++) begin
      int p = t / P;
      int s = t % P;
      int base = p * s_eff;
      logic [65:0] e_col = '0;
      if (t < n * P) begin
        for (int i = 0; i < K; i++) e_col[base + i] = 1'b1;
        // R3: half-period strobes
        check({pix_rst, pix_samp, pwrdn} == {1'(s < H - 1), 1'(s >= H && s < P - 1), 1'(s < H)},
              "R3", "rst/samp/pwrdn", {pix_rst, pix_samp, pwrdn},
              {1'(s < H - 1), 1'(s >= H && s < P - 1), 1'(s < H)});
        if (s == H - 1 || s == P - 1)
          check(!pix_rst && !pix_samp, "R4", "guard gap", {pix_rst, pix_samp}, 0);
        if (p == 0)
          check(col_en == 66'h7, "R2", "first window", col_en, 66'h7);
        else
          check(col_en == e_col, "R6", "window columns", col_en, e_col);
        check(col_valid == (s == P - 1), "R5", "valid strobe", col_valid, 1'(s == P - 1));
        if (s == P - 1)
          check(col_idx == 7'(base + 1), "R5", "centre index", col_idx, base + 1);
        check(!done, "R7", "done early", done, 0);
        if (poke && t > 40)
          check(wt_out == w, "R8", "weights after busy start", wt_out, w);
        else
          check(wt_out == w, "R2", "latched weights", wt_out, w);
      end else begin
        check(done, "R7", "done pulse", done, 1);
        check(col_en == '0 && pwrdn, "R9", "idle at done", {col_en, pwrdn}, 1);
      end
      if (poke && t == 40) begin
        start = 1'b1; weights = 36'h123456789; stride = 3'd7;  // R8 stimulus
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    check(!done, "R7", "done one cycle", done, 0);
    check(pwrdn && col_en == '0 && !col_valid, "R9", "idle after frame",
          {pwrdn, col_en, col_valid}, {1'b1, 67'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pwrdn && col_en == '0 && !pix_rst && !pix_samp && !col_valid && !done && wt_out == '0,
          "R1", "reset outputs", {pwrdn, col_en, pix_rst, pix_samp, col_valid, done},
          {1'b1, 70'b0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pwrdn && col_en == '0, "R9", "idle before start", {pwrdn, col_en}, {1'b1, 66'b0});
    run_frame(1, 36'h9ABCDEF01, 1'b1);
    for (int sv = 0; sv < 8; sv++) begin
      run_frame(sv, 36'(sv * 36'h111111111 + 36'h5A), 1'b0);
      repeat (2) @(negedge clk);
      check(pwrdn && !col_valid, "R9", "idle gap", {pwrdn, col_valid}, 2'b10);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule